// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a TLB miss. Given a 32-bit virtual address and the base of the current page directory, it walks a two-level page table held in memory and produces either the 32-bit physical address or a fault. The virtual address is split into three fields:

- the upper ten bits select a directory slot;
- the next ten bits select a slot in the page table that the directory entry names;
- the low twelve bits are the byte offset within the page.

The walk uses exactly two dependent word reads on a request/grant memory port. Read data returns on a separate response strobe. Every entry is four bytes wide, and bit 0 of an entry marks it present.

A TLB sits in front of the walker and launches a walk with a valid/ready pair. The walker accepts a new walk only while it is idle. When the walk finishes, a one-cycle completion pulse carries the following, which the TLB uses to refill:

- the virtual page number;
- the physical page number;
- the full physical address;
- the fault flag.

A fault means the walk found an entry with the present bit clear. In that case the TLB must not refill.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and on the first cycle after it, `walk_ready` is 1, `mem_req` is 0 and `done` is 0.
- R2: The first memory request goes to address `{root_base[31:12], 12'b0} | (walk_va[31:22] << 2)`. Low bits of `root_base` are ignored. While `mem_gnt` is 0, `mem_req` and `mem_addr` hold steady.
- R3: The second request goes to `{pde[31:12], 12'b0} | (walk_va[21:12] << 2)`, where `pde` is the word returned by the first read. The second request is issued only after that response has arrived.
- R4: For a successful walk, `done_vpn` is `walk_va[31:12]`, `done_ppn` is `pte[31:12]`, `done_pa` is `{pte[31:12], walk_va[11:0]}` and `done_fault` is 0. Here `pte` is the word returned by the second read.
- R5: If bit 0 of the directory entry is 0, the walk ends with `done_fault` equal to 1 and `done_ppn` equal to 0, with no second request. `mem_req` is 0 while `done` is high.
- R6: If bit 0 of the table entry is 0, the walk ends with `done_fault` equal to 1, `done_ppn` equal to 0 and `done_pa` equal to `{20'b0, walk_va[11:0]}`.
- R7: `done` lasts exactly one cycle. `walk_ready` is 1 only while idle, never together with `done`. A walk is accepted only when `walk_valid` and `walk_ready` are both 1. Changes to `walk_va`, `root_base` or `walk_valid` while a walk is busy have no effect on its result.
- R8: A successful walk makes exactly two granted requests, and a faulting directory walk makes exactly one. `mem_req` drops in the cycle after a grant. A `mem_rvalid` pulse while a request is still waiting for its grant is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| walk_valid | input | 1 | Walk request from the TLB |
| walk_ready | output | 1 | Walker is idle and takes a request |
| walk_va | input | 32 | Virtual address to translate |
| root_base | input | 32 | Page directory base (low 12 bits ignored) |
| mem_req | output | 1 | Memory read request |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| done | output | 1 | One-cycle completion pulse |
| done_vpn | output | 20 | Virtual page number of the finished walk |
| done_ppn | output | 20 | Physical page number (0 on fault) |
| done_pa | output | 32 | Translated physical address |
| done_fault | output | 1 | Walk hit a non-present entry |

## Verification
Two events can meet in one cycle:

- the completion pulse of one walk and a still-asserted request for the next walk;
- a stray read-response strobe and a memory request that is still waiting for its grant.

The bench provokes the first case by holding `walk_valid` high through a whole walk while `walk_va` is scrambled. It then checks two things. First, `walk_ready` stays low during the pulse. Second, the result still reflects the address captured when the walk was accepted. The bench provokes the second case by injecting random `mem_rvalid` pulses with garbage data in cycles where it withholds the grant. It judges the outcome from the exact entry addresses, the grant count, and the final translation.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
    localparam int unsigned ADDR_W      = 32;
    localparam int unsigned OFF_W       = 12;
    localparam int unsigned IDX_W       = 10;
    localparam int unsigned ENTRY_SHIFT = 2;
    localparam int unsigned VPN_W       = ADDR_W - OFF_W;
    localparam int unsigned PRESENT_BIT = 0;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [VPN_W-1:0]  vpn_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_DIR,
        ST_WAIT_DIR,
        ST_READ_TBL,
        ST_WAIT_TBL,
        ST_DONE
    } walk_state_e;

    typedef struct packed {
        vpn_t ppn;
        logic fault;
    } walk_result_t;

    // Clear the in-page bits of a word, leaving a 4 KB frame address.
    function automatic addr_t frame_of(addr_t w);
        return {w[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    endfunction

    // Byte address of slot idx in the table whose frame is given.
    function automatic addr_t slot_addr(addr_t frame, idx_t idx);
        return frame_of(frame) | (addr_t'(idx) << ENTRY_SHIFT);
    endfunction

    function automatic idx_t dir_idx(addr_t va);
        return va[ADDR_W-1 -: IDX_W];
    endfunction

    function automatic idx_t tbl_idx(addr_t va);
        return va[OFF_W +: IDX_W];
    endfunction
endpackage

// File: rtl/ptw_ctrl.sv
`timescale 1ns/1ps
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        walk_valid,
    input  logic        mem_gnt,
    input  logic        mem_rvalid,
    input  logic        entry_present,
    output walk_state_e state_o
);
    walk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:     if (walk_valid) state_d = ST_READ_DIR;
            ST_READ_DIR: if (mem_gnt)    state_d = ST_WAIT_DIR;
            ST_WAIT_DIR: if (mem_rvalid) state_d = entry_present ? ST_READ_TBL : ST_DONE;
            ST_READ_TBL: if (mem_gnt)    state_d = ST_WAIT_TBL;
            ST_WAIT_TBL: if (mem_rvalid) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/ptw_datapath.sv
`timescale 1ns/1ps
module ptw_datapath
    import ptw_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  walk_state_e  state,
    input  logic         walk_valid,
    input  addr_t        walk_va,
    input  addr_t        root_base,
    input  logic         mem_rvalid,
    input  addr_t        mem_rdata,
    output logic         entry_present,
    output logic         mem_req,
    output addr_t        mem_addr,
    output addr_t        va_o,
    output walk_result_t result_o
);
    addr_t        va_q;
    addr_t        dir_frame_q;
    addr_t        tbl_frame_q;
    walk_result_t res_q;
    addr_t        entry_frame;

    assign entry_present = mem_rdata[PRESENT_BIT];
    assign entry_frame   = frame_of(mem_rdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q        <= '0;
            dir_frame_q <= '0;
            tbl_frame_q <= '0;
            res_q       <= '0;
        end else begin
            case (state)
                ST_IDLE: if (walk_valid) begin
                    va_q        <= walk_va;
                    dir_frame_q <= frame_of(root_base);
                    res_q       <= '0;
                end
                ST_WAIT_DIR: if (mem_rvalid) begin
                    tbl_frame_q <= entry_frame;
                    res_q.fault <= ~entry_present;
                end
                ST_WAIT_TBL: if (mem_rvalid) begin
                    res_q.ppn   <= entry_present ? entry_frame[ADDR_W-1:OFF_W] : '0;
                    res_q.fault <= ~entry_present;
                end
                default: ;
            endcase
        end
    end

    assign mem_req  = (state == ST_READ_DIR) || (state == ST_READ_TBL);
    assign mem_addr = (state == ST_READ_TBL) ? slot_addr(tbl_frame_q, tbl_idx(va_q))
                                             : slot_addr(dir_frame_q, dir_idx(va_q));
    assign va_o     = va_q;
    assign result_o = res_q;
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              walk_valid,
    output logic              walk_ready,
    input  logic [ADDR_W-1:0] walk_va,
    input  logic [ADDR_W-1:0] root_base,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              done,
    output logic [VPN_W-1:0]  done_vpn,
    output logic [VPN_W-1:0]  done_ppn,
    output logic [ADDR_W-1:0] done_pa,
    output logic              done_fault
);
    walk_state_e  state;
    logic         entry_present;
    addr_t        va_q;
    walk_result_t result;

    ptw_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .walk_valid    (walk_valid),
        .mem_gnt       (mem_gnt),
        .mem_rvalid    (mem_rvalid),
        .entry_present (entry_present),
        .state_o       (state)
    );

    ptw_datapath u_dp (
        .clk           (clk),
        .rst           (rst),
        .state         (state),
        .walk_valid    (walk_valid),
        .walk_va       (walk_va),
        .root_base     (root_base),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .entry_present (entry_present),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .va_o          (va_q),
        .result_o      (result)
    );

    assign walk_ready = (state == ST_IDLE);
    assign done       = (state == ST_DONE);
    assign done_vpn   = va_q[ADDR_W-1:OFF_W];
    assign done_ppn   = result.ppn;
    assign done_pa    = {result.ppn, va_q[OFF_W-1:0]};
    assign done_fault = result.fault;
endmodule

// File: rtl/ptw_checker.sv
`timescale 1ns/1ps
module ptw_checker
    import ptw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              walk_valid,
    input logic              walk_ready,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done,
    input logic              done_fault,
    input logic [VPN_W-1:0]  done_ppn,
    input logic [ADDR_W-1:0] done_pa
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr)); // R2
    AST_FAULT_NO_PPN: assert property (@(posedge clk) disable iff (rst)
        done && done_fault |-> done_ppn == '0); // R5
    AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req); // R5
    AST_FAULT_PA_HIGH: assert property (@(posedge clk) disable iff (rst)
        done && done_fault |-> done_pa[ADDR_W-1:OFF_W] == '0); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_READY_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !walk_ready); // R7
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        walk_valid && walk_ready |=> !walk_ready && !done); // R7
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_gnt |=> !mem_req); // R8
endmodule

bind pt_walker ptw_checker chk_i (.*);

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        walk_valid;
    logic        walk_ready;
    logic [31:0] walk_va;
    logic [31:0] root_base;
    logic        mem_req;
    logic        mem_gnt;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        done;
    logic [19:0] done_vpn;
    logic [19:0] done_ppn;
    logic [31:0] done_pa;
    logic        done_fault;

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    int unsigned seed_dummy;

    logic [31:0] exp_dir_addr, exp_tbl_addr, pde_val, pte_val;
    logic        stray_en = 1'b0;
    int unsigned grants = 0;
    logic        pending = 1'b0;
    logic [31:0] pend_data;
    int unsigned pend_cnt = 0;

    always #2.5 clk = ~clk;

    pt_walker dut_i (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] slot(logic [31:0] frame, logic [9:0] idx);
        return {frame[31:12], 12'b0} | ({22'b0, idx} << 2);
    endfunction

    // Memory responder: random grant and response delay, stray strobes.
    initial begin
        mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            mem_gnt = 1'b0;
            mem_rvalid = 1'b0;
            if (pending) begin
                if (pend_cnt == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = pend_data;
                    pending    = 1'b0;
                end else pend_cnt--;
            end else if (mem_req) begin
                if ($urandom_range(0, 2) != 0) begin
                    mem_gnt = 1'b1;
                    grants++;
                    if (grants == 1) begin
                        check(mem_addr == exp_dir_addr, "R2 dir addr", mem_addr, exp_dir_addr);
                        pend_data = pde_val;
                    end else begin
                        check(mem_addr == exp_tbl_addr, "R3 tbl addr", mem_addr, exp_tbl_addr);
                        pend_data = pte_val;
                    end
                    pending  = 1'b1;
                    pend_cnt = $urandom_range(0, 3);
                end else if (stray_en) begin
                    mem_rvalid = 1'b1;           // R8 stray strobe while ungranted
                    mem_rdata  = $urandom;
                end
            end
        end
    end

    task automatic run_walk(input logic [31:0] va, input logic [31:0] base,
                            input logic [31:0] pde, input logic [31:0] pte,
                            input bit hold, input bit stray);
        logic        fault;
        logic [19:0] eppn;
        int          n;
        fault        = !pde[0] || !pte[0];
        eppn         = fault ? 20'h0 : pte[31:12];
        exp_dir_addr = slot(base, va[31:22]);
        exp_tbl_addr = slot(pde, va[21:12]);
        pde_val      = pde;
        pte_val      = pte;
        grants       = 0;
        stray_en     = stray;
        @(negedge clk);
        check(walk_ready == 1'b1, "R7 ready idle", 32'(walk_ready), 32'd1);
        walk_valid = 1'b1; walk_va = va; root_base = base;
        @(negedge clk);
        walk_valid = hold;
        walk_va    = $urandom;
        root_base  = $urandom;
        n = 0;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, "R7 done seen", 32'(done), 32'd1);
        check(walk_ready == 1'b0, "R7 not ready at done", 32'(walk_ready), 32'd0);
        check(mem_req == 1'b0, "R5 no req at done", 32'(mem_req), 32'd0);
        check(done_vpn == va[31:12], "R4 vpn", 32'(done_vpn), 32'(va[31:12]));
        check(done_fault == fault, !pde[0] ? "R5 dir fault" : "R6 tbl fault", 32'(done_fault), 32'(fault));
        check(done_ppn == eppn, fault ? "R6 ppn zero" : "R4 ppn", 32'(done_ppn), 32'(eppn));
        check(done_pa == {eppn, va[11:0]}, fault ? "R6 pa" : "R4 pa", done_pa, {eppn, va[11:0]});
        check(grants == (pde[0] ? 2 : 1), "R8 grant count", grants, pde[0] ? 32'd2 : 32'd1);
        walk_valid = 1'b0;
        stray_en   = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && walk_ready == 1'b1 && mem_req == 1'b0, "R7 pulse ends",
              {29'b0, done, walk_ready, mem_req}, 32'h2);
    endtask

    initial begin
        int unsigned cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_checks++; n_fails++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc);
                $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin
        seed_dummy = $urandom(32'd20240611);
        rst = 1'b1; walk_valid = 1'b0; walk_va = '0; root_base = '0;
        repeat (3) @(negedge clk);
        check(walk_ready == 1 && mem_req == 0 && done == 0, "R1 in reset",
              {29'b0, walk_ready, mem_req, done}, 32'h4);
        rst = 1'b0;
        @(negedge clk);
        check(walk_ready == 1 && mem_req == 0 && done == 0, "R1 after reset",
              {29'b0, walk_ready, mem_req, done}, 32'h4);

        // Directed corners
        run_walk(32'h1234_5678, 32'h0040_0000, 32'h0001_0003, 32'h1000_0007, 0, 0); // R4
        run_walk(32'h0000_0000, 32'h0040_0ABC, 32'h0002_0FFF, 32'hABCD_E001, 0, 0); // R2 low bits ignored
        run_walk(32'hFFFF_FFFF, 32'hFFFF_F000, 32'hFFFF_F001, 32'hFFFF_FFFF, 1, 1); // R7 hold, R8 stray
        run_walk(32'h8040_2123, 32'h0010_0000, 32'h0003_0000, 32'h1111_1111, 0, 1); // R5 dir fault
        run_walk(32'h8040_2FED, 32'h0010_0000, 32'h0003_0001, 32'h2222_2FFE, 1, 0); // R6 tbl fault

        // Constrained random walks
        for (int i = 0; i < 60; i++) begin
            logic [31:0] pde, pte;
            pde = $urandom;
            pte = $urandom;
            pde[0] = ($urandom_range(0, 9) != 0);
            pte[0] = ($urandom_range(0, 9) != 0);
            run_walk($urandom, $urandom, pde, pte, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule